// File: doc/BRIEF.md
# SD Host Command and Status Register Front End

This block is the register-mapped front end of an SD card host controller. Software reaches it over a simple synchronous 16-bit read/write port. A write to the command word decodes the word into an index, a direction flag, a command class and a response class. The block then raises a one-cycle launch pulse toward the card-side engine. The 32-bit command argument is built from two 16-bit halves, and the engine sees it as one vector.

The engine does the protocol work and the timeout counting. It reports back on input wires: command completion, response timeout, card status error and a 128-bit response. The front end records these events in a status register. Software clears the status bits by writing ones to them. A level interrupt line is asserted whenever a recorded event is also enabled in the interrupt-enable register. The response is stored into eight read-only 16-bit registers, with its byte pairs in reversed register order. A card-detect input is watched for insertion edges, and each edge sets its own status bit.

Top module: `sd_host_regs`

## Requirements
- R1: After reset, every readable register reads 0, `irq` is low and `cmd_go` is low.
- R2: A write to offset 0x00 stores the word, which reads back at 0x00. In the next cycle `cmd_go` is high for exactly one cycle, with `cmd_index` = bits 5:0, `cmd_dir` = bit 15, `cmd_type` = bits 13:12 and `cmd_rsp` = bits 10:8 of the written word.
- R3: Offset 0x04 holds argument bits 15:0 and offset 0x08 holds bits 31:16. A write to either offset changes only its own half of `cmd_arg`.
- R4: The interrupt-enable register at offset 0x14 keeps bits 14:0. Bit 15 always reads 0.
- R5: `irq` is high exactly when some status bit and the same interrupt-enable bit are both 1.
- R6: A cycle with `cmd_done` high sets status bit 0. A cycle with `rsp_timeout` high sets bit 7. A cycle with `card_err` high sets bit 14. Status reads at offset 0x10.
- R7: Writing to offset 0x10 clears each status bit written as 1 and leaves the other bits unchanged. `irq` follows in the same cycle as the status bit. If an event sets a bit in the same cycle as a write clears it, the bit stays set.
- R8: A cycle with `rsp_valid` high captures `rsp_bytes`. Byte j of the response is `rsp_bytes[8j+7:8j]`. The register at offset 0x40 + 4*(7-k) holds byte 2k in bits 15:8 and byte 2k+1 in bits 7:0.
- R9: Writes to offsets 0x40 through 0x5C leave the response registers unchanged.
- R10: A 0-to-1 transition of `card_detect` sets status bit 1. A level held high does not set the bit again after it has been cleared.
- R11: Offset 0x18 keeps 8 bits of command timeout and offset 0x1C keeps 16 bits of data timeout. The upper 8 bits at 0x18 read 0.
- R12: A read of any offset not listed above returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from `bus_addr` |
| cmd_go | output | 1 | One-cycle command launch pulse |
| cmd_index | output | 6 | Decoded command index |
| cmd_dir | output | 1 | Decoded transfer direction |
| cmd_type | output | 2 | Decoded command class |
| cmd_rsp | output | 3 | Decoded response class |
| cmd_arg | output | 32 | Assembled command argument |
| cmd_done | input | 1 | Command completion event from the engine |
| rsp_timeout | input | 1 | Response timeout event |
| card_err | input | 1 | Card status error event |
| rsp_valid | input | 1 | Response capture strobe |
| rsp_bytes | input | 128 | Response bytes, byte j in bits 8j+7:8j |
| card_detect | input | 1 | Card presence level |
| irq | output | 1 | Level interrupt request |

## Verification
Two functions can act on one status bit in the same cycle: a software write-one-to-clear and an event from the engine or from card detect. The bench provokes the collision by driving `cmd_done` high during the same clock as a clear write to bit 0. It does the same with a card insertion edge against a clear of bit 1. A collision is judged correct if the bit reads 1 afterwards and `irq` stays high while that bit is enabled. The bench also checks that a clear with no competing event drops both the bit and `irq` together.

// File: rtl/sdh_pkg.sv
package sdh_pkg;

  localparam logic [7:0] OFS_CMD  = 8'h00;
  localparam logic [7:0] OFS_ARGL = 8'h04;
  localparam logic [7:0] OFS_ARGH = 8'h08;
  localparam logic [7:0] OFS_STAT = 8'h10;
  localparam logic [7:0] OFS_IEN  = 8'h14;
  localparam logic [7:0] OFS_CTMO = 8'h18;
  localparam logic [7:0] OFS_DTMO = 8'h1C;
  localparam logic [7:0] OFS_RSP  = 8'h40;

  localparam int ST_DONE = 0;
  localparam int ST_CARD = 1;
  localparam int ST_TMO  = 7;
  localparam int ST_ERR  = 14;

  typedef struct packed {
    logic       dir;
    logic [1:0] ctype;
    logic [2:0] rtype;
    logic [5:0] idx;
  } cmd_fields_t;

  function automatic cmd_fields_t split_cmd(input logic [15:0] w);
    cmd_fields_t f;
    f.idx   = w[5:0];
    f.dir   = w[15];
    f.ctype = w[13:12];
    f.rtype = w[10:8];
    return f;
  endfunction

  function automatic logic [15:0] join_pair(input logic [7:0] even_b, input logic [7:0] odd_b);
    return {even_b, odd_b};
  endfunction

  function automatic logic [15:0] w1c_apply(input logic [15:0] cur, input logic [15:0] clr,
                                             input logic [15:0] set);
    return (cur & ~clr) | set;
  endfunction

endpackage

// File: rtl/sdh_cmd_decode.sv
module sdh_cmd_decode
  import sdh_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [15:0] wdata,
  output logic [15:0] cmd_word,
  output logic        cmd_go,
  output cmd_fields_t fields
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_word <= '0;
      cmd_go   <= 1'b0;
      fields   <= '0;
    end else begin
      cmd_go <= wr_en;
      if (wr_en) begin
        cmd_word <= wdata;
        fields   <= split_cmd(wdata);
      end
    end
  end

  // R2
  go_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> cmd_go);
  // R2
  go_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> !cmd_go);
  // R2
  index_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (fields.idx == $past(wdata[5:0]) && fields.dir == $past(wdata[15])));

endmodule

// File: rtl/sdh_status.sv
module sdh_status
  import sdh_pkg::*;
#(
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] set_vec,
  input  logic          clr_wr,
  input  logic [SW-1:0] clr_data,
  input  logic          ie_wr,
  input  logic [SW-1:0] ie_data,
  output logic [SW-1:0] status_q,
  output logic [SW-1:0] ie_q,
  output logic          irq
);

  localparam logic [SW-1:0] IE_KEEP = {1'b0, {(SW-1){1'b1}}};

  logic [SW-1:0] clr_eff;
  logic [SW-1:0] pending;

  assign clr_eff = clr_wr ? clr_data : '0;
  assign pending = status_q & ie_q;
  assign irq     = |pending;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= '0;
      ie_q     <= '0;
    end else begin
      status_q <= w1c_apply(status_q, clr_eff, set_vec);
      if (ie_wr) ie_q <= ie_data & IE_KEEP;
    end
  end

  // R6
  done_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_vec[ST_DONE] |=> status_q[ST_DONE]);
  // R7
  clear_tmo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && clr_data[ST_TMO] && !set_vec[ST_TMO]) |=> !status_q[ST_TMO]);
  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && clr_data[ST_DONE] && set_vec[ST_DONE]) |=> status_q[ST_DONE]);
  // R5
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec[ST_DONE] && ie_q[ST_DONE] && !ie_wr) |=> irq);
  // R4
  ie_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ie_wr |=> (ie_q == ($past(ie_data) & IE_KEEP)));

endmodule

// File: rtl/sdh_rsp_store.sv
module sdh_rsp_store
  import sdh_pkg::*;
#(
  parameter int NREG = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               capture,
  input  logic [16*NREG-1:0] bytes_in,
  output logic [16*NREG-1:0] rsp_flat
);

  genvar k;
  generate
    for (k = 0; k < NREG; k++) begin : g_pair
      logic [15:0] pair_w;
      assign pair_w = join_pair(bytes_in[16*k +: 8], bytes_in[16*k+8 +: 8]);
      always_ff @(posedge clk) begin
        if (!rst_n)       rsp_flat[16*(NREG-1-k) +: 16] <= '0;
        else if (capture) rsp_flat[16*(NREG-1-k) +: 16] <= pair_w;
      end
    end
  endgenerate

  // R8
  top_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (rsp_flat[16*(NREG-1) +: 16] == {$past(bytes_in[7:0]), $past(bytes_in[15:8])}));
  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(rsp_flat));

endmodule

// File: rtl/sd_host_regs.sv
module sd_host_regs
  import sdh_pkg::*;
#(
  parameter int AW   = 8,
  parameter int NRSP = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [AW-1:0]     bus_addr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic              cmd_go,
  output logic [5:0]        cmd_index,
  output logic              cmd_dir,
  output logic [1:0]        cmd_type,
  output logic [2:0]        cmd_rsp,
  output logic [31:0]       cmd_arg,
  input  logic              cmd_done,
  input  logic              rsp_timeout,
  input  logic              card_err,
  input  logic              rsp_valid,
  input  logic [16*NRSP-1:0] rsp_bytes,
  input  logic              card_detect,
  output logic              irq
);

  localparam int          IW       = (NRSP > 1) ? $clog2(NRSP) : 1;
  localparam logic [AW-1:0] RSP_LO = AW'(OFS_RSP);
  localparam logic [AW-1:0] RSP_HI = AW'(OFS_RSP + 4 * (NRSP - 1));

  logic [15:0]        arg_lo, arg_hi;
  logic [7:0]         ctmo_q;
  logic [15:0]        dtmo_q;
  logic               cd_q;
  logic               cd_rise;
  logic [15:0]        set_vec;
  logic [15:0]        status_q, ie_q;
  logic [15:0]        cmd_word;
  cmd_fields_t        fields;
  logic [16*NRSP-1:0] rsp_flat;
  logic               in_rsp;
  logic               rsp_wr_try;
  logic [IW-1:0]      rsp_idx;
  logic [AW-1:0]      rsp_off;

  logic wr_cmd, wr_argl, wr_argh, wr_stat, wr_ien, wr_ctmo, wr_dtmo;
  assign wr_cmd  = bus_wr && (bus_addr == AW'(OFS_CMD));
  assign wr_argl = bus_wr && (bus_addr == AW'(OFS_ARGL));
  assign wr_argh = bus_wr && (bus_addr == AW'(OFS_ARGH));
  assign wr_stat = bus_wr && (bus_addr == AW'(OFS_STAT));
  assign wr_ien  = bus_wr && (bus_addr == AW'(OFS_IEN));
  assign wr_ctmo = bus_wr && (bus_addr == AW'(OFS_CTMO));
  assign wr_dtmo = bus_wr && (bus_addr == AW'(OFS_DTMO));

  assign in_rsp     = (bus_addr >= RSP_LO) && (bus_addr <= RSP_HI) && (bus_addr[1:0] == 2'b00);
  assign rsp_wr_try = bus_wr && in_rsp;
  assign rsp_off    = bus_addr - RSP_LO;
  assign rsp_idx    = IW'(rsp_off >> 2);

  assign cd_rise = card_detect && !cd_q;

  always_comb begin
    set_vec          = '0;
    set_vec[ST_DONE] = cmd_done;
    set_vec[ST_CARD] = cd_rise;
    set_vec[ST_TMO]  = rsp_timeout;
    set_vec[ST_ERR]  = card_err;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arg_lo <= '0;
      arg_hi <= '0;
      ctmo_q <= '0;
      dtmo_q <= '0;
      cd_q   <= 1'b1;
    end else begin
      cd_q <= card_detect;
      if (wr_argl) arg_lo <= bus_wdata;
      if (wr_argh) arg_hi <= bus_wdata;
      if (wr_ctmo) ctmo_q <= bus_wdata[7:0];
      if (wr_dtmo) dtmo_q <= bus_wdata;
    end
  end

  assign cmd_arg = {arg_hi, arg_lo};

  sdh_cmd_decode u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_cmd),
    .wdata    (bus_wdata),
    .cmd_word (cmd_word),
    .cmd_go   (cmd_go),
    .fields   (fields)
  );

  assign cmd_index = fields.idx;
  assign cmd_dir   = fields.dir;
  assign cmd_type  = fields.ctype;
  assign cmd_rsp   = fields.rtype;

  sdh_status #(.SW(16)) u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_vec  (set_vec),
    .clr_wr   (wr_stat),
    .clr_data (bus_wdata),
    .ie_wr    (wr_ien),
    .ie_data  (bus_wdata),
    .status_q (status_q),
    .ie_q     (ie_q),
    .irq      (irq)
  );

  sdh_rsp_store #(.NREG(NRSP)) u_rsp (
    .clk      (clk),
    .rst_n    (rst_n),
    .capture  (rsp_valid),
    .bytes_in (rsp_bytes),
    .rsp_flat (rsp_flat)
  );

  always_comb begin
    bus_rdata = '0;
    if (in_rsp) bus_rdata = rsp_flat[16*rsp_idx +: 16];
    else if (bus_addr == AW'(OFS_CMD))  bus_rdata = cmd_word;
    else if (bus_addr == AW'(OFS_ARGL)) bus_rdata = arg_lo;
    else if (bus_addr == AW'(OFS_ARGH)) bus_rdata = arg_hi;
    else if (bus_addr == AW'(OFS_STAT)) bus_rdata = status_q;
    else if (bus_addr == AW'(OFS_IEN))  bus_rdata = ie_q;
    else if (bus_addr == AW'(OFS_CTMO)) bus_rdata = {8'h00, ctmo_q};
    else if (bus_addr == AW'(OFS_DTMO)) bus_rdata = dtmo_q;
  end

  // R10
  insert_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cd_rise |=> status_q[ST_CARD]);
  // R9
  rsp_readonly_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_wr_try && !rsp_valid) |=> $stable(rsp_flat));
  // R3
  arg_low_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_argl |=> (cmd_arg[31:16] == $past(cmd_arg[31:16])));
  // R3
  arg_high_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_argh |=> (cmd_arg[15:0] == $past(cmd_arg[15:0])));

endmodule

// File: tb/test_sd_host_regs.sv
module test_sd_host_regs;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_wr = 1'b0;
  logic [7:0]   bus_addr = '0;
  logic [15:0]  bus_wdata = '0;
  logic [15:0]  bus_rdata;
  logic         cmd_go;
  logic [5:0]   cmd_index;
  logic         cmd_dir;
  logic [1:0]   cmd_type;
  logic [2:0]   cmd_rsp;
  logic [31:0]  cmd_arg;
  logic         cmd_done = 1'b0;
  logic         rsp_timeout = 1'b0;
  logic         card_err = 1'b0;
  logic         rsp_valid = 1'b0;
  logic [127:0] rsp_bytes = '0;
  logic         card_detect = 1'b0;
  logic         irq;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  sd_host_regs i_sd_host_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmd_go(cmd_go),
    .cmd_index(cmd_index), .cmd_dir(cmd_dir), .cmd_type(cmd_type),
    .cmd_rsp(cmd_rsp), .cmd_arg(cmd_arg), .cmd_done(cmd_done),
    .rsp_timeout(rsp_timeout), .card_err(card_err), .rsp_valid(rsp_valid),
    .rsp_bytes(rsp_bytes), .card_detect(card_detect), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic t_reset;
    logic [15:0] v;
    foreach (i_list[i]) begin
      rd(i_list[i], v);
      chk("R1 reset register", 32'(v), 32'h0);
    end
    chk("R1 reset irq", 32'(irq), 0);
    chk("R1 reset cmd_go", 32'(cmd_go), 0);
  endtask

  logic [7:0] i_list [0:8] = '{8'h00, 8'h04, 8'h08, 8'h10, 8'h14, 8'h18, 8'h1C, 8'h40, 8'h5C};

  task automatic t_cmd(input logic [15:0] w);
    logic [15:0] v;
    wr(8'h00, w);
    chk("R2 cmd_go pulse", 32'(cmd_go), 1);
    chk("R2 index", 32'(cmd_index), 32'(w[5:0]));
    chk("R2 dir", 32'(cmd_dir), 32'(w[15]));
    chk("R2 type", 32'(cmd_type), 32'(w[13:12]));
    chk("R2 rsp class", 32'(cmd_rsp), 32'(w[10:8]));
    @(negedge clk);
    chk("R2 pulse ends", 32'(cmd_go), 0);
    rd(8'h00, v);
    chk("R2 readback", 32'(v), 32'(w));
  endtask

  task automatic t_arg;
    wr(8'h04, 16'hBEEF);
    wr(8'h08, 16'h1234);
    chk("R3 arg full", cmd_arg, 32'h1234BEEF);
    wr(8'h04, 16'h0F0F);
    chk("R3 low write keeps high", cmd_arg, 32'h12340F0F);
    wr(8'h08, 16'hA5A5);
    chk("R3 high write keeps low", cmd_arg, 32'hA5A50F0F);
  endtask

  task automatic pulse_events(input logic d, input logic t, input logic e);
    @(negedge clk);
    cmd_done = d; rsp_timeout = t; card_err = e;
    @(negedge clk);
    cmd_done = 0; rsp_timeout = 0; card_err = 0;
  endtask

  task automatic t_ie_events;
    logic [15:0] v;
    wr(8'h14, 16'hFFFF);
    rd(8'h14, v);
    chk("R4 enable bit15 dropped", 32'(v), 32'h7FFF);
    wr(8'h14, 16'h0000);
    pulse_events(1, 0, 0);
    rd(8'h10, v);
    chk("R6 done sets bit0", 32'(v), 32'h0001);
    chk("R5 irq low when masked", 32'(irq), 0);
    wr(8'h14, 16'h0001);
    chk("R5 irq high when enabled", 32'(irq), 1);
    pulse_events(0, 1, 1);
    rd(8'h10, v);
    chk("R6 timeout bit7 and error bit14", 32'(v), 32'h4081);
    wr(8'h10, 16'h0080);
    rd(8'h10, v);
    chk("R7 clear bit7 only", 32'(v), 32'h4001);
    wr(8'h10, 16'h0001);
    chk("R7 irq drops with bit0", 32'(irq), 0);
    wr(8'h14, 16'h4000);
    chk("R5 irq from bit14", 32'(irq), 1);
    wr(8'h10, 16'h4000);
    chk("R7 irq drops with bit14", 32'(irq), 0);
  endtask

  task automatic t_race;
    logic [15:0] v;
    wr(8'h14, 16'h0001);
    pulse_events(1, 0, 0);
    @(negedge clk);
    bus_wr = 1; bus_addr = 8'h10; bus_wdata = 16'h0001; cmd_done = 1;
    @(negedge clk);
    bus_wr = 0; cmd_done = 0;
    rd(8'h10, v);
    chk("R7 set wins over clear", 32'(v[0]), 1);
    chk("R7 irq stays high", 32'(irq), 1);
    wr(8'h10, 16'h0001);
    rd(8'h10, v);
    chk("R7 plain clear", 32'(v), 32'h0);
  endtask

  task automatic t_rsp(input logic [7:0] base);
    logic [15:0] v;
    @(negedge clk);
    for (int j = 0; j < 16; j++) rsp_bytes[8*j +: 8] = base + 8'(j * 7);
    rsp_valid = 1;
    @(negedge clk);
    rsp_valid = 0;
    rsp_bytes = '0;
    for (int k = 0; k < 8; k++) begin
      logic [15:0] exp;
      exp = {base + 8'(2 * k * 7), base + 8'((2 * k + 1) * 7)};
      rd(8'(8'h40 + 4 * (7 - k)), v);
      chk("R8 response pair", 32'(v), 32'(exp));
    end
  endtask

  task automatic t_rsp_ro;
    logic [15:0] v0, v1;
    rd(8'h48, v0);
    wr(8'h48, ~v0);
    wr(8'h5C, 16'h0000);
    rd(8'h48, v1);
    chk("R9 response write ignored", 32'(v1), 32'(v0));
    rd(8'h5C, v1);
    chk("R9 last response write ignored", 32'(v1), 32'({8'h30, 8'h37}));
  endtask

  task automatic t_card;
    logic [15:0] v;
    wr(8'h14, 16'h0002);
    @(negedge clk); card_detect = 1;
    @(negedge clk);
    rd(8'h10, v);
    chk("R10 insertion sets bit1", 32'(v), 32'h0002);
    chk("R10 irq on insertion", 32'(irq), 1);
    wr(8'h10, 16'h0002);
    repeat (3) @(negedge clk);
    rd(8'h10, v);
    chk("R10 held level no re-set", 32'(v), 32'h0);
    card_detect = 0;
    wr(8'h14, 16'h0000);
    @(negedge clk);
    bus_wr = 1; bus_addr = 8'h10; bus_wdata = 16'h0002; card_detect = 1;
    @(negedge clk);
    bus_wr = 0;
    rd(8'h10, v);
    chk("R10 R7 insertion beats clear", 32'(v), 32'h0002);
    wr(8'h10, 16'h0002);
  endtask

  task automatic t_tmo_unmapped;
    logic [15:0] v;
    wr(8'h18, 16'hABCD);
    rd(8'h18, v);
    chk("R11 command timeout 8 bits", 32'(v), 32'h00CD);
    wr(8'h1C, 16'hFEDC);
    rd(8'h1C, v);
    chk("R11 data timeout 16 bits", 32'(v), 32'hFEDC);
    wr(8'h20, 16'h1111);
    rd(8'h20, v);
    chk("R12 unmapped 0x20", 32'(v), 0);
    rd(8'h0C, v);
    chk("R12 unmapped 0x0C", 32'(v), 0);
    rd(8'h42, v);
    chk("R12 unaligned in response range", 32'(v), 0);
    rd(8'h60, v);
    chk("R12 past response range", 32'(v), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_cmd(16'h8000 | 16'h2000 | 16'h0200 | 16'd17);
    t_cmd(16'h1500 | 16'd41);
    t_cmd(16'h003F);
    t_arg();
    t_ie_events();
    t_race();
    t_rsp(8'h10);
    t_rsp(8'h30);
    t_rsp_ro();
    t_card();
    t_tmo_unmapped();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

endmodule